// File: doc/BRIEF.md
# Pattern-Table Bank Mapper

This block sits between the picture processor's pattern-table fetch port and a larger character ROM. The processor sees an 8 KB pattern window. The block splits that window into eight 1 KB slots, and each slot holds the index of the ROM bank it currently shows. Every fetch address is turned into an extended ROM address: the index of the selected slot goes on top, and the 10-bit offset inside the 1 KB bank goes below it.

The CPU changes the slot contents through a small write port, a register number plus a data byte. A static style input chooses how those writes are read:

- **Whole-window switch.** One write picks one of two 8 KB groups.
- **Half-window switch.** Two registers each load one 4 KB half.
- **Command/data pair.** A command write picks one of six bank registers, and a following data write fills it. Two of the six registers map 2 KB pairs and four map single 1 KB banks. One command bit exchanges the two halves of the window.

Every programmed bank index wraps to the ROM size, which is a parameter given as a count of 1 KB banks.

Top module: `pattern_bank_mapper`

## Requirements
- R1: After reset, slot i (0..7) holds bank i. The command selector and the swap bit are zero. The six bank registers of style 2 hold 0, 2, 4, 5, 6 and 7.
- R2: `romAddr` equals {bank of slot `ppuAddr[12:10]`, `ppuAddr[9:0]`}. It follows `ppuAddr` combinationally. `ppuAddr[13]` is not decoded.
- R3: Every bank index written into a slot keeps only its low log2(BANK_COUNT) bits. BANK_COUNT must be a power of two, at least 8.
- R4: With `mapStyle` = 2'b00, any write loads slot i with base+i. The base is 8 when `wrData[2]` is 1 and 0 when it is 0. The other data bits and `wrReg` have no effect.
- R5: With `mapStyle` = 2'b01, a write to register 6 loads slots 0..3 with 4·data+0..3. A write to register 7 loads slots 4..7 with 4·data+0..3. Writes to any other register change nothing.
- R6: With `mapStyle` = 2'b10, a write with `wrReg[0]` = 0 is a command write. Command bits [2:0] are the register selector and bit 7 is the swap bit. A write with `wrReg[0]` = 1 is a data write into the selected bank register. Selector values 6 and 7 make a data write change nothing.
- R7: In style 2, bank register 0 maps value&~1 to logical slot 0 and value|1 to logical slot 1. Bank register 1 does the same for logical slots 2 and 3.
- R8: In style 2, bank registers 2, 3, 4 and 5 each map their value to logical slots 4, 5, 6 and 7.
- R9: In style 2, physical slot = logical slot XOR (swap bit · 4). A command write re-maps all slots at once, with no data write needed.
- R10: With `mapStyle` = 2'b11, writes change nothing.
- R11: Without `wrEn`, the slots never change. This holds even when `mapStyle` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mapStyle | input | 2 | Write interpretation: 0 whole window, 1 half window, 2 command/data, 3 writes off |
| wrEn | input | 1 | CPU write strobe, one cycle per write |
| wrReg | input | 3 | Register number of the write |
| wrData | input | 8 | Write data |
| ppuAddr | input | 14 | Pattern fetch address |
| romAddr | output | log2(BANK_COUNT)+10 | Extended character ROM address |

## Verification
The bench drives half-window writes whose 4·data lands far past the ROM end, for example data 0xFF on a 128-bank ROM, which must give banks 124..127. A mapper that skipped the wrap would show address bits above the ROM. In style 2 it programs odd values into the pair registers. A design that did not force bit 0 would map the odd bank twice. It also checks a lone command write carrying the swap bit right after reset, which must show slots 4..7 in front of 0..3. It then checks that data writes under selector 6 or 7, half-style writes to other registers, writes in the disabled style, and changes of `mapStyle` alone all leave every slot as it was, read back through `romAddr`.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  localparam int SLOT_COUNT = 8;
  localparam int BANK_REG_COUNT = 6;
  localparam int DATA_W = 8;
  localparam int BASE_W = 11;
  localparam logic [2:0] HALF_LOW_REG = 3'd6;
  localparam logic [2:0] HALF_HIGH_REG = 3'd7;

  typedef enum logic [1:0] {
    STYLE_FULL8   = 2'd0,
    STYLE_HALF4   = 2'd1,
    STYLE_CMDDATA = 2'd2,
    STYLE_OFF     = 2'd3
  } mapStyle_e;

  // Strobes from the write decoder to the slot datapath.
  typedef struct packed {
    logic [SLOT_COUNT-1:0] slotLoad;   // which physical slots take a new bank
    logic                  linear;     // consecutive banks from linearBase
    logic                  span8;      // offset spans 0..7 instead of 0..3
    logic [BASE_W-1:0]     linearBase; // first bank of a linear load
    logic                  swapHalves; // XOR logical slot with 4
  } slotStrobe_t;

  typedef logic [BANK_REG_COUNT-1:0][DATA_W-1:0] bankRegs_t;

  // Reset contents of the six bank registers: identity mapping.
  function automatic logic [DATA_W-1:0] bankResetVal(input int k);
    if (k < 2) return DATA_W'(2 * k);
    else return DATA_W'(k + 2);
  endfunction

  // Value shown by a logical slot in the command/data style.
  function automatic logic [DATA_W-1:0] cmdSlotValue(input logic [2:0] logical,
                                                     input bankRegs_t regs);
    logic [DATA_W-1:0] v;
    case (logical)
      3'd0: v = regs[0] & ~DATA_W'(1);
      3'd1: v = regs[0] | DATA_W'(1);
      3'd2: v = regs[1] & ~DATA_W'(1);
      3'd3: v = regs[1] | DATA_W'(1);
      3'd4: v = regs[2];
      3'd5: v = regs[3];
      3'd6: v = regs[4];
      default: v = regs[5];
    endcase
    return v;
  endfunction

endpackage

// File: rtl/pbm_write_ctrl.sv
module pbm_write_ctrl
  import pbm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  mapStyle,
  input  logic        wrEn,
  input  logic [2:0]  wrReg,
  input  logic [7:0]  wrData,
  output slotStrobe_t strobe,
  output bankRegs_t   bankNext
);

  mapStyle_e style;
  assign style = mapStyle_e'(mapStyle);

  bankRegs_t  bankQ, bankD;
  logic [2:0] cmdSelQ, cmdSelD;
  logic       cmdSwapQ, cmdSwapD;

  logic cmdWrite, dataWrite, selValid;
  assign cmdWrite  = wrEn && (style == STYLE_CMDDATA) && !wrReg[0];
  assign dataWrite = wrEn && (style == STYLE_CMDDATA) && wrReg[0];
  assign selValid  = (cmdSelQ < 3'(BANK_REG_COUNT));

  always_comb begin
    strobe   = '0;
    bankD    = bankQ;
    cmdSelD  = cmdSelQ;
    cmdSwapD = cmdSwapQ;
    if (wrEn) begin
      case (style)
        STYLE_FULL8: begin
          strobe.slotLoad   = '1;
          strobe.linear     = 1'b1;
          strobe.span8      = 1'b1;
          strobe.linearBase = wrData[2] ? BASE_W'(SLOT_COUNT) : '0;
        end
        STYLE_HALF4: begin
          if (wrReg == HALF_LOW_REG) begin
            strobe.slotLoad   = 8'h0F;
            strobe.linear     = 1'b1;
            strobe.linearBase = {1'b0, wrData, 2'b00};
          end else if (wrReg == HALF_HIGH_REG) begin
            strobe.slotLoad   = 8'hF0;
            strobe.linear     = 1'b1;
            strobe.linearBase = {1'b0, wrData, 2'b00};
          end
        end
        STYLE_CMDDATA: begin
          if (!wrReg[0]) begin
            cmdSelD         = wrData[2:0];
            cmdSwapD        = wrData[7];
            strobe.slotLoad = '1;
          end else if (selValid) begin
            for (int k = 0; k < BANK_REG_COUNT; k++) begin
              if (cmdSelQ == 3'(k)) bankD[k] = wrData;
            end
            strobe.slotLoad = '1;
          end
        end
        default: ;
      endcase
    end
    strobe.swapHalves = cmdSwapD;
  end

  assign bankNext = bankD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdSelQ  <= '0;
      cmdSwapQ <= 1'b0;
      for (int k = 0; k < BANK_REG_COUNT; k++) bankQ[k] <= bankResetVal(k);
    end else begin
      cmdSelQ  <= cmdSelD;
      cmdSwapQ <= cmdSwapD;
      bankQ    <= bankD;
    end
  end

  // R10
  off_style_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && style == STYLE_OFF) |-> (strobe.slotLoad == '0));

  // R5
  half_other_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && style == STYLE_HALF4 && wrReg != HALF_LOW_REG && wrReg != HALF_HIGH_REG)
      |-> (strobe.slotLoad == '0));

  // R6
  bad_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrite && cmdSelQ >= 3'(BANK_REG_COUNT)) |=> $stable(bankQ));

  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdWrite |=> ($stable(cmdSelQ) && $stable(cmdSwapQ)));

  // R4
  full_all_slots_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && style == STYLE_FULL8) |-> ($countones(strobe.slotLoad) == SLOT_COUNT));

endmodule

// File: rtl/pbm_slot_path.sv
module pbm_slot_path
  import pbm_pkg::*;
#(
  parameter int BANK_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  slotStrobe_t        strobe,
  input  bankRegs_t          bankNext,
  input  logic [12:0]        winAddr,
  output logic [BANK_W+9:0]  romAddr
);

  localparam int SUM_W = 16;

  logic [SLOT_COUNT-1:0][BANK_W-1:0] slotQ, slotD;

  generate
    for (genvar p = 0; p < SLOT_COUNT; p++) begin : g_slot
      logic [2:0]       logical;
      logic [2:0]       linOffset;
      logic [SUM_W-1:0] linSum;
      logic [DATA_W-1:0] cmdVal;

      assign logical   = 3'(p) ^ {strobe.swapHalves, 2'b00};
      assign linOffset = strobe.span8 ? 3'(p) : {1'b0, 2'(p)};
      assign linSum    = SUM_W'(strobe.linearBase) + SUM_W'(linOffset);
      assign cmdVal    = cmdSlotValue(logical, bankNext);

      always_comb begin
        if (!strobe.slotLoad[p]) slotD[p] = slotQ[p];
        else if (strobe.linear)  slotD[p] = BANK_W'(linSum);
        else                     slotD[p] = BANK_W'(cmdVal);
      end

      always_ff @(posedge clk) begin
        if (!rstN) slotQ[p] <= BANK_W'(p);
        else       slotQ[p] <= slotD[p];
      end
    end
  endgenerate

  assign romAddr = {slotQ[winAddr[12:10]], winAddr[9:0]};

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.slotLoad == '0) |=> $stable(slotQ));

  // R5
  half_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.slotLoad == 8'h0F && strobe.linear) |=> (slotQ[1] == BANK_W'(slotQ[0] + 1'b1)));

  // R7
  pair_even_odd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.slotLoad == '1 && !strobe.linear && !strobe.swapHalves)
      |=> (!slotQ[0][0] && slotQ[1] == (slotQ[0] | BANK_W'(1))));

  // R9
  swapped_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.slotLoad == '1 && !strobe.linear && strobe.swapHalves)
      |=> (!slotQ[4][0] && slotQ[5] == (slotQ[4] | BANK_W'(1))));

endmodule

// File: rtl/pattern_bank_mapper.sv
module pattern_bank_mapper
  import pbm_pkg::*;
#(
  parameter int BANK_COUNT = 128,
  localparam int BANK_W = $clog2(BANK_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mapStyle,
  input  logic              wrEn,
  input  logic [2:0]        wrReg,
  input  logic [7:0]        wrData,
  input  logic [13:0]       ppuAddr,
  output logic [BANK_W+9:0] romAddr
);

  slotStrobe_t strobe;
  bankRegs_t   bankNext;
  logic        unusedWindowBit;

  assign unusedWindowBit = ppuAddr[13];

  pbm_write_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .mapStyle (mapStyle),
    .wrEn     (wrEn),
    .wrReg    (wrReg),
    .wrData   (wrData),
    .strobe   (strobe),
    .bankNext (bankNext)
  );

  pbm_slot_path #(.BANK_W(BANK_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .bankNext (bankNext),
    .winAddr  (ppuAddr[12:0]),
    .romAddr  (romAddr)
  );

  // R3
  initial size_pow2_chk: assert (BANK_COUNT >= 8 && BANK_W <= 16 && (1 << BANK_W) == BANK_COUNT);

endmodule

// File: tb/sim_pattern_bank_mapper.sv
module sim_pattern_bank_mapper;

  localparam int NB = 128;
  localparam int BW = 7;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    mapStyle = 2'd0;
  logic          wrEn = 1'b0;
  logic [2:0]    wrReg = 3'd0;
  logic [7:0]    wrData = 8'd0;
  logic [13:0]   ppuAddr = 14'd0;
  logic [BW+9:0] romAddr;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int expBank [8];
  int regModel [6];
  int swapModel;

  always #10 clk = ~clk;

  pattern_bank_mapper #(.BANK_COUNT(NB)) u0 (
    .clk(clk), .rstN(rstN), .mapStyle(mapStyle), .wrEn(wrEn),
    .wrReg(wrReg), .wrData(wrData), .ppuAddr(ppuAddr), .romAddr(romAddr)
  );

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 8; i++) expBank[i] = i;
    regModel = '{0, 2, 4, 5, 6, 7};
    swapModel = 0;
  endtask

  task automatic doWrite(input logic [2:0] r, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrReg = r;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkSlots(input string tag, input bit hiBit);
    for (int s = 0; s < 8; s++) begin
      logic [BW+9:0] want;
      ppuAddr = {hiBit, 3'(s), 10'(37 * s + 5)};
      #1;
      want = {BW'(expBank[s] % NB), ppuAddr[9:0]};
      checks++;
      if (romAddr !== want) begin
        fails++;
        $display("FAIL %s slot %0d actual %h expected %h", tag, s, romAddr, want);
      end
    end
  endtask

  // model of the command/data style, R7 R8 R9
  task automatic applyCmdModel();
    int v [8];
    v[0] = regModel[0] & ~1; v[1] = regModel[0] | 1;
    v[2] = regModel[1] & ~1; v[3] = regModel[1] | 1;
    for (int k = 0; k < 4; k++) v[4 + k] = regModel[2 + k];
    for (int l = 0; l < 8; l++) expBank[l ^ (swapModel * 4)] = v[l] % NB;
  endtask

  task automatic testReset();
    doReset();
    checkSlots("R1 reset identity", 1'b0);
    checkSlots("R2 bit13 ignored", 1'b1);
  endtask

  task automatic testFull8();
    doReset();
    mapStyle = 2'd0;
    doWrite(3'd5, 8'h04);
    for (int i = 0; i < 8; i++) expBank[i] = 8 + i;
    checkSlots("R4 upper group", 1'b0);
    doWrite(3'd0, 8'hFB);
    for (int i = 0; i < 8; i++) expBank[i] = i;
    checkSlots("R4 bit2 clear", 1'b0);
  endtask

  task automatic testHalf4();
    doReset();
    mapStyle = 2'd1;
    doWrite(3'd6, 8'h03);
    for (int i = 0; i < 4; i++) expBank[i] = 12 + i;
    checkSlots("R5 low half", 1'b0);
    doWrite(3'd7, 8'h21);
    for (int i = 0; i < 4; i++) expBank[4 + i] = (132 + i) % NB;
    checkSlots("R3 R5 high half wraps", 1'b0);
    doWrite(3'd6, 8'hFF);
    for (int i = 0; i < 4; i++) expBank[i] = 124 + i;
    checkSlots("R3 top of rom", 1'b0);
    doWrite(3'd5, 8'h11);
    checkSlots("R5 other reg ignored", 1'b0);
  endtask

  task automatic testOffAndIdle();
    doReset();
    mapStyle = 2'd1;
    doWrite(3'd7, 8'h05);
    for (int i = 0; i < 4; i++) expBank[4 + i] = 20 + i;
    mapStyle = 2'd3;
    doWrite(3'd6, 8'h09);
    doWrite(3'd0, 8'h84);
    checkSlots("R10 style off ignored", 1'b0);
    mapStyle = 2'd0;
    repeat (3) @(negedge clk);
    mapStyle = 2'd2;
    repeat (3) @(negedge clk);
    checkSlots("R11 style change alone", 1'b0);
  endtask

  task automatic testCmdData();
    doReset();
    mapStyle = 2'd2;
    doWrite(3'd0, 8'h80);
    swapModel = 1;
    applyCmdModel();
    checkSlots("R9 R1 swap after reset", 1'b0);
    doWrite(3'd0, 8'h00);
    swapModel = 0;
    doWrite(3'd1, 8'h13);
    regModel[0] = 8'h13;
    applyCmdModel();
    checkSlots("R7 pair reg0 odd value", 1'b0);
    doWrite(3'd2, 8'h01);
    doWrite(3'd3, 8'h20);
    regModel[1] = 8'h20;
    for (int k = 2; k < 6; k++) begin
      doWrite(3'd4, 8'(k));
      doWrite(3'd5, 8'(8'h40 + k));
      regModel[k] = 8'h40 + k;
    end
    applyCmdModel();
    checkSlots("R8 R6 single regs", 1'b0);
    doWrite(3'd0, 8'h06);
    doWrite(3'd1, 8'h55);
    doWrite(3'd0, 8'h07);
    doWrite(3'd1, 8'h66);
    checkSlots("R6 selector 6 7 ignored", 1'b0);
    doWrite(3'd0, 8'h85);
    swapModel = 1;
    applyCmdModel();
    checkSlots("R9 swap halves", 1'b0);
    doWrite(3'd1, 8'hFF);
    regModel[5] = 8'hFF;
    applyCmdModel();
    checkSlots("R3 R9 wrap under swap", 1'b0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual running expected done");
    finish();
  end

  initial begin
    testReset();
    testFull8();
    testHalf4();
    testOffAndIdle();
    testCmdData();
    finish();
  end

endmodule